// File: doc/BRIEF.md
# SGRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous graphics RAM. It takes the memory from power-on to the ready state. After reset it keeps clock-enable and the data mask high and drives only no-operation commands until a stabilization interval has passed. The interval is counted in clock cycles, from a clock-frequency parameter and a microsecond parameter. It then precharges both banks and issues a configurable number of auto-refresh commands and one mode register set. An optional special mode register write, which sets the load-color and load-mask controls, follows as the last step.

The mode fields arrive as static configuration inputs. They are checked against the legal encodings when the precharge is issued and captured in that same cycle. If any field is illegal, the sequencer stops after the precharge. It raises an error flag, writes no mode register and never reports completion. A configuration bit swaps the order of the refresh burst and the mode register set. Every command is followed by a parameterized settling gap filled with no-operation cycles.

Top module: `sgram_init_seq`

## Requirements
- R1: From reset until `CLK_MHZ*STABLE_US` cycles have elapsed, `mem_cke` and `mem_dqm` are 1, only NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1) is driven, and `init_done` and `init_err` are 0.
- R2: The first command after the stabilization interval is precharge-all: code 0,0,1,0 with `mem_addr[10]`=1 and all other address bits 0.
- R3: Exactly max(`N_REF`,2) auto-refresh commands (code 0,0,0,1, address 0) are issued.
- R4: The mode register set uses code 0,0,0,0 with `mem_spec`=0. Its address is {A10=0, A9=write-single, A8..A7=test mode, A6..A4=CAS latency, A3=burst type, A2..A0=burst length}.
- R5: With `cfg_mrs_first`=0 the refresh burst comes before the mode register set. With `cfg_mrs_first`=1 the mode register set comes first.
- R6: The next command starts exactly `T_RP` cycles after a precharge, `T_RC` cycles after a refresh and `T_MRD` cycles after a mode or special-mode write. NOP is driven in between.
- R7: Legal burst-length codes are 000, 001, 010 and 011, plus 111 with burst type 0. The only legal CAS-latency codes are 010 and 011. The test-mode field must be 00.
- R8: An illegal configuration raises `init_err` `T_RP` cycles after the precharge. After the precharge only NOP is issued, and `init_done` stays 0.
- R9: With `cfg_spec_en`=1 a special write (code 0,0,0,0, `mem_spec`=1, A6=color load, A5=mask load, other bits 0) is the last command. Setting both loads is illegal. With `cfg_spec_en`=0 the two load inputs are ignored.
- R10: `init_done` rises one final gap after the last command and stays high, and `mem_dqm` falls to 0 with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_bl | input | 3 | Burst-length code |
| cfg_bt | input | 1 | Burst type, 0 sequential, 1 interleave |
| cfg_cl | input | 3 | CAS-latency code |
| cfg_tm | input | 2 | Test-mode field, must be 00 |
| cfg_wbs | input | 1 | Burst read with single-location write |
| cfg_mrs_first | input | 1 | Mode register set before the refresh burst |
| cfg_spec_en | input | 1 | Issue the special mode write |
| cfg_color_ld | input | 1 | Load-color control for the special write |
| cfg_mask_ld | input | 1 | Load-mask control for the special write |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cke | output | 1 | Clock enable |
| mem_dqm | output | 1 | Data mask |
| mem_bank | output | 1 | Bank select, held 0 |
| mem_addr | output | ADDR_W | Address bus |
| mem_spec | output | 1 | Marks the special mode write |
| init_done | output | 1 | Initialization complete |
| init_err | output | 1 | Illegal configuration, sequence halted |

## Verification
A corrupted step counter or next-step choice shows on the command pins as a missing, extra or reordered command. The scoreboard catches it on the first command that differs from the expected stream. A wrong gap load moves the next command by some cycles, and the spacing check catches it at that command. A wrong legality decision shows `T_RP` cycles after the precharge: a mode write appears where only NOP is allowed, or the error flag rises when it should not. A timer that expires early or late moves the precharge outside its window.

// File: rtl/sgram_init_pkg.sv
package sgram_init_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_SMRS,
    ST_GAP,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_pins_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_pins_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sgram_rst_sync.sv
module sgram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sgram_cfg_check.sv
module sgram_cfg_check #(
  parameter int AW = 11
) (
  input  logic [2:0]    burst_len,
  input  logic          burst_type,
  input  logic [2:0]    cas_lat,
  input  logic [1:0]    test_mode,
  input  logic          wr_single,
  input  logic          spec_en,
  input  logic          color_ld,
  input  logic          mask_ld,
  output logic          cfg_ok,
  output logic [AW-1:0] mode_word,
  output logic [AW-1:0] spec_word
);
  logic bl_ok, cl_ok, spec_ok;

  always_comb begin
    case (burst_len)
      3'b000, 3'b001, 3'b010, 3'b011: bl_ok = 1'b1;
      3'b111:                         bl_ok = !burst_type;   // full page: sequential only
      default:                        bl_ok = 1'b0;
    endcase
    cl_ok   = (cas_lat == 3'b010) || (cas_lat == 3'b011);
    spec_ok = !(spec_en && color_ld && mask_ld);
    cfg_ok  = bl_ok && cl_ok && (test_mode == 2'b00) && spec_ok;
  end

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = burst_len;
    mode_word[3]   = burst_type;
    mode_word[6:4] = cas_lat;
    mode_word[8:7] = test_mode;
    mode_word[9]   = wr_single;
    spec_word      = '0;
    spec_word[6]   = color_ld;
    spec_word[5]   = mask_ld;
  end
endmodule

// File: rtl/sgram_gap_timer.sv
module sgram_gap_timer #(
  parameter int W     = 8,
  parameter int START = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(START);
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sgram_init_seq.sv
module sgram_init_seq
  import sgram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int STABLE_US = 200,
  parameter int N_REF     = 2,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  parameter int ADDR_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_bl,
  input  logic              cfg_bt,
  input  logic [2:0]        cfg_cl,
  input  logic [1:0]        cfg_tm,
  input  logic              cfg_wbs,
  input  logic              cfg_mrs_first,
  input  logic              cfg_spec_en,
  input  logic              cfg_color_ld,
  input  logic              cfg_mask_ld,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_cke,
  output logic              mem_dqm,
  output logic              mem_bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_spec,
  output logic              init_done,
  output logic              init_err
);
  localparam int WAIT_CYC = CLK_MHZ * STABLE_US;
  localparam int N_EFF    = (N_REF < 2) ? 2 : N_REF;
  localparam int TMR_W    = $clog2(WAIT_CYC + T_RP + T_RC + T_MRD + 1);
  localparam int REF_W    = $clog2(N_EFF + 1);
  localparam int AP_BIT   = 10;

  logic rst_n_s;
  sgram_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  logic              cfg_ok;
  logic [ADDR_W-1:0] mode_w, spec_w;
  sgram_cfg_check #(.AW(ADDR_W)) u_chk (
    .burst_len(cfg_bl), .burst_type(cfg_bt), .cas_lat(cfg_cl), .test_mode(cfg_tm),
    .wr_single(cfg_wbs), .spec_en(cfg_spec_en), .color_ld(cfg_color_ld),
    .mask_ld(cfg_mask_ld), .cfg_ok(cfg_ok), .mode_word(mode_w), .spec_word(spec_w)
  );

  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  sgram_gap_timer #(.W(TMR_W), .START(WAIT_CYC - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  seq_state_e        state_q, state_d, ret_q, ret_d, step_next;
  logic [REF_W-1:0]  ref_cnt_q, ref_cnt_d;
  logic [ADDR_W-1:0] mode_q, spec_q;
  logic              mrs_first_q, spec_en_q;
  logic              cap_en, issue, mrs_first_now;
  int                step_gap;
  cmd_pins_t         cmd;

  assign cap_en        = (state_q == ST_PRE);
  assign mrs_first_now = cap_en ? cfg_mrs_first : mrs_first_q;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    ret_d     = ret_q;
    ref_cnt_d = ref_cnt_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    issue     = 1'b0;
    step_gap  = 1;
    step_next = ST_DONE;
    case (state_q)
      ST_WAIT: if (tmr_exp) state_d = ST_PRE;
      ST_PRE: begin
        issue    = 1'b1;
        step_gap = T_RP;
        if (!cfg_ok)            step_next = ST_ERR;
        else if (mrs_first_now) step_next = ST_MRS;
        else                    step_next = ST_REF;
      end
      ST_REF: begin
        issue     = 1'b1;
        step_gap  = T_RC;
        ref_cnt_d = ref_cnt_q + 1'b1;
        if (int'(ref_cnt_q) + 1 < N_EFF) step_next = ST_REF;
        else if (!mrs_first_q)           step_next = ST_MRS;
        else                             step_next = spec_en_q ? ST_SMRS : ST_DONE;
      end
      ST_MRS: begin
        issue    = 1'b1;
        step_gap = T_MRD;
        if (mrs_first_q) step_next = ST_REF;
        else             step_next = spec_en_q ? ST_SMRS : ST_DONE;
      end
      ST_SMRS: begin
        issue     = 1'b1;
        step_gap  = T_MRD;
        step_next = ST_DONE;
      end
      ST_GAP:  if (tmr_exp) state_d = ret_q;
      default: state_d = state_q;
    endcase
    if (issue) begin
      if (step_gap > 1) begin
        state_d  = ST_GAP;
        ret_d    = step_next;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(step_gap - 2);
      end else begin
        state_d  = step_next;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_WAIT;
      ret_q     <= ST_WAIT;
      ref_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      ret_q     <= ret_d;
      ref_cnt_q <= ref_cnt_d;
    end
  end

  // configuration capture, enabled in the precharge cycle
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q      <= '0;
      spec_q      <= '0;
      mrs_first_q <= 1'b0;
      spec_en_q   <= 1'b0;
    end else if (cap_en) begin
      mode_q      <= mode_w;
      spec_q      <= spec_w;
      mrs_first_q <= cfg_mrs_first;
      spec_en_q   <= cfg_spec_en;
    end
  end

  // pin decode
  always_comb begin
    cmd      = CMD_NOP;
    mem_addr = '0;
    mem_spec = 1'b0;
    case (state_q)
      ST_PRE:  begin cmd = CMD_PRE; mem_addr[AP_BIT] = 1'b1; end
      ST_REF:  cmd = CMD_REF;
      ST_MRS:  begin cmd = CMD_MRS; mem_addr = mode_q; end
      ST_SMRS: begin cmd = CMD_MRS; mem_addr = spec_q; mem_spec = 1'b1; end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;
  assign mem_cke   = 1'b1;
  assign mem_bank  = 1'b0;
  assign init_done = (state_q == ST_DONE);
  assign init_err  = (state_q == ST_ERR);
  assign mem_dqm   = !init_done;

  // R6: a precharge with a gap longer than one cycle is followed by NOP
  a_r6_pre_gap: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((cmd == CMD_PRE) && (T_RP > 1)) |=> (cmd == CMD_NOP));

  // R8: once halted on a bad configuration the pins stay quiet
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    init_err |=> (init_err && !init_done && (cmd == CMD_NOP)));

  // R10: completion is sticky and releases the data mask
  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    init_done |=> (init_done && !mem_dqm));

  // R3: a mode write after the refresh burst sees the full refresh count
  a_r3_ref_total: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((cmd == CMD_MRS) && !mem_spec && !mrs_first_q) |-> (ref_cnt_q == REF_W'(N_EFF)));

  // R9: the special write never carries both load controls
  a_r9_spec_excl: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_spec |-> !(mem_addr[6] && mem_addr[5]));

endmodule

// File: tb/test_sgram_init_seq.sv
module test_sgram_init_seq;
  localparam int CLK_MHZ   = 100;
  localparam int STABLE_US = 2;
  localparam int N_REF     = 1;
  localparam int T_RP      = 3;
  localparam int T_RC      = 5;
  localparam int T_MRD     = 2;
  localparam int ADDR_W    = 11;
  localparam int WAIT_CYC  = CLK_MHZ * STABLE_US;
  localparam int N_EXP     = (N_REF < 2) ? 2 : N_REF;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  logic clk, rst_n;
  logic [2:0] cfg_bl, cfg_cl;
  logic [1:0] cfg_tm;
  logic cfg_bt, cfg_wbs, cfg_mrs_first, cfg_spec_en, cfg_color_ld, cfg_mask_ld;
  logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_cke, mem_dqm, mem_bank, mem_spec;
  logic [ADDR_W-1:0] mem_addr;
  logic init_done, init_err;

  sgram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .N_REF(N_REF),
    .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .ADDR_W(ADDR_W)
  ) i_sgram_init_seq (
    .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cfg_bt(cfg_bt), .cfg_cl(cfg_cl),
    .cfg_tm(cfg_tm), .cfg_wbs(cfg_wbs), .cfg_mrs_first(cfg_mrs_first),
    .cfg_spec_en(cfg_spec_en), .cfg_color_ld(cfg_color_ld), .cfg_mask_ld(cfg_mask_ld),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_cke(mem_cke), .mem_dqm(mem_dqm), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .mem_spec(mem_spec), .init_done(init_done), .init_err(init_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [3:0]        cmd;
    logic [ADDR_W-1:0] addr;
    logic              spec;
    int                gap;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int    n_checks, n_fails;
  int    cyc, last_cyc, exp_done_gap;
  bit    mon_on, done_seen, side_bad;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [ADDR_W-1:0] a,
                      input logic s, input int g, input string r);
    exp_t e;
    e.cmd = c; e.addr = a; e.spec = s; e.gap = g;
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  // monitor: pops the scoreboard as commands appear on the pins
  always @(negedge clk) begin
    if (mon_on) begin
      logic [3:0] cmd_now;
      cyc++;
      cmd_now = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
      if (!init_done && !init_err && (mem_dqm !== 1'b1 || mem_cke !== 1'b1)) side_bad = 1'b1;
      if (cmd_now !== C_NOP) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected command", cmd_now, C_NOP);
        end else begin
          exp_t  e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(cmd_now === e.cmd, r, "command code", cmd_now, e.cmd);
          chk(mem_addr === e.addr, r, "address", mem_addr, e.addr);
          chk(mem_spec === e.spec, "R9", "special marker", mem_spec, e.spec);
          if (e.gap < 0)
            chk(cyc >= WAIT_CYC && cyc <= WAIT_CYC + 3, "R1", "stabilization length", cyc, WAIT_CYC);
          else
            chk(cyc - last_cyc == e.gap, "R6", "command spacing", cyc - last_cyc, e.gap);
        end
        last_cyc = cyc;
      end
      if (init_done && !done_seen) begin
        done_seen = 1'b1;
        chk(cyc - last_cyc == exp_done_gap, "R10", "done delay", cyc - last_cyc, exp_done_gap);
      end
    end
  end

  // driver: builds the expected command stream from the requirements
  task automatic run_case(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                          input logic [1:0] tm, input logic ws, input logic mf,
                          input logic se, input logic cc, input logic mc);
    bit legal;
    int g;
    logic [ADDR_W-1:0] mw, sw;
    legal = ((bl <= 3'b011) || (bl == 3'b111 && !bt))      // R7 burst length
            && (cl == 3'b010 || cl == 3'b011)               // R7 CAS latency
            && (tm == 2'b00)                                // R7 test mode
            && !(se && cc && mc);                           // R9 exclusive loads
    mw = {1'b0, ws, tm, cl, bt, bl};
    sw = '0; sw[6] = cc; sw[5] = mc;
    @(negedge clk);
    rst_n = 1'b0; mon_on = 1'b0;
    cfg_bl = bl; cfg_bt = bt; cfg_cl = cl; cfg_tm = tm; cfg_wbs = ws;
    cfg_mrs_first = mf; cfg_spec_en = se; cfg_color_ld = cc; cfg_mask_ld = mc;
    exp_q.delete(); req_q.delete();
    repeat (3) @(negedge clk);
    chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} === C_NOP, "R1", "reset command", 0, 0);
    chk(mem_cke === 1'b1 && mem_dqm === 1'b1, "R1", "reset cke/dqm", {mem_cke, mem_dqm}, 2'b11);
    chk(init_done === 1'b0 && init_err === 1'b0, "R1", "reset flags", {init_done, init_err}, 0);
    push(C_PRE, ADDR_W'(11'h400), 1'b0, -1, "R2");
    g = T_RP;
    if (legal) begin
      if (mf) begin push(C_MRS, mw, 1'b0, g, "R5"); g = T_MRD; end
      for (int i = 0; i < N_EXP; i++) begin push(C_REF, '0, 1'b0, g, "R3"); g = T_RC; end
      if (!mf) begin push(C_MRS, mw, 1'b0, g, "R4"); g = T_MRD; end
      if (se) begin push(C_MRS, sw, 1'b1, g, "R9"); g = T_MRD; end
    end
    exp_done_gap = g;
    cyc = 0; last_cyc = 0; done_seen = 1'b0; side_bad = 1'b0;
    rst_n = 1'b1; mon_on = 1'b1;
    for (int k = 0; k < WAIT_CYC + 400; k++) begin
      @(negedge clk);
      if (init_done || init_err) break;
    end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "commands left unissued", exp_q.size(), 0);
    chk(init_done === legal, "R10", "done flag", init_done, legal);
    chk(init_err === !legal, "R8", "error flag", init_err, !legal);
    chk(mem_dqm === !legal, "R10", "dqm after sequence", mem_dqm, !legal);
    chk(!side_bad, "R1", "cke/dqm high while initializing", side_bad, 0);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; mon_on = 1'b0; rst_n = 1'b0;
    cfg_bl = '0; cfg_bt = 0; cfg_cl = 3'b010; cfg_tm = '0; cfg_wbs = 0;
    cfg_mrs_first = 0; cfg_spec_en = 0; cfg_color_ld = 0; cfg_mask_ld = 0;
    // R4 R5: refresh first, burst 8, latency 2, single write
    run_case(3'b011, 1'b0, 3'b010, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R5 R7 R9: mode first, full page sequential, latency 3, color load
    run_case(3'b111, 1'b0, 3'b011, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    // R9: interleave burst 4 with mask load
    run_case(3'b010, 1'b1, 3'b011, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    // R9: both loads set but special write disabled, so ignored
    run_case(3'b000, 1'b1, 3'b010, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    // R7 R8: full page with interleave
    run_case(3'b111, 1'b1, 3'b010, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7 R8: reserved burst code
    run_case(3'b100, 1'b0, 3'b010, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7 R8: reserved CAS latency
    run_case(3'b001, 1'b0, 3'b001, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7 R8: nonzero test mode
    run_case(3'b001, 1'b0, 3'b011, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8 R9: both loads with special write enabled
    run_case(3'b010, 1'b0, 3'b010, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule